// File: doc/BRIEF.md
# SPI Mode-3 Flow-Controlled Slave

This block is the serial front end of a device that a host drives over a four-wire SPI link. It works only in mode 3. SCLK, slave select and MOSI are brought into a faster system clock through two-flop synchronisers, and edges are found on the synchronised copies. The system clock must run at least 8 times faster than SCLK. Each transaction begins with a command byte. While the host shifts that byte in, the block shifts a device status byte out on MISO. Both bytes go MSB first.

If the command calls for a data phase, the bytes that follow pass through a 32-byte FIFO. When the host writes, the FIFO is emptied by a local consumer port. When the host reads, a local producer port fills it. At byte boundaries a ready/busy output tells the host to hold SCLK high while the FIFO cannot accept the next byte or cannot supply it. Command decoding goes only as far as picking the data direction. The full command byte is passed on to the logic behind the block.

Top module: `spi_flow_slave`

## Requirements
- R1: MOSI is sampled on rising SCLK edges, MSB first. After the eighth rising edge, the command byte appears on cmd_o, and cmd_valid_o pulses for exactly one system cycle.
- R2: status_i is captured when slave select falls. It is shifted out on MISO, MSB first, during the command byte.
- R3: miso_oe_o is low while slave select is high and high during a transaction. MISO is updated only after falling SCLK edges.
- R4: A command above 0x0F with bit 7 set selects write mode. Every following data byte is pushed into the FIFO, and the consumer port delivers the bytes in arrival order.
- R5: A command above 0x0F with bit 7 clear selects read mode. Bytes from the producer port are shifted out on MISO, MSB first, in the order they were pushed.
- R6: Commands 0x00 to 0x0F have no data phase. Later bytes in the same transaction neither push nor pop the FIFO, and the data direction is left unchanged.
- R7: In write mode, rdy_o goes low after a byte that fills the FIFO. It goes high again once the consumer removes a byte.
- R8: In read mode, rdy_o goes low after a byte boundary at which the FIFO is empty. It goes high once a byte is available, and that byte is the next one sent.
- R9: Raising slave select in the middle of a byte aborts the byte. The partial byte is neither pushed nor popped, and the next transaction starts again with a command byte.
- R10: A data command that reverses the data direction discards whatever the FIFO holds.
- R11: After reset, rdy_o is high, the FIFO is empty, read mode is selected and prod_ready_o is high.
- R12: prod_ready_o is high only in read mode while the FIFO is not full. cons_valid_o is high only in write mode while the FIFO is not empty. The FIFO never holds more than 32 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host, idles high |
| ss_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| rdy_o | output | 1 | High when the host may clock the next byte |
| status_i | input | 8 | Device status, shifted out during the command byte |
| cmd_o | output | 8 | Last command byte received |
| cmd_valid_o | output | 1 | One-cycle pulse when a command byte completes |
| prod_valid_i | input | 1 | Producer has a byte for the host |
| prod_data_i | input | 8 | Producer byte |
| prod_ready_o | output | 1 | FIFO accepts a producer byte |
| cons_valid_o | output | 1 | FIFO holds a byte written by the host |
| cons_data_o | output | 8 | Head byte for the consumer |
| cons_ready_i | input | 1 | Consumer takes the head byte |

## Verification
Several properties are checked on every cycle:
- ready/busy drops only at a byte boundary;
- the command strobe lasts a single cycle;
- MISO is released one cycle after slave select rises;
- the FIFO count stays within its depth and is never popped when empty;
- a command without a data phase never moves data.

Some behaviour shows only in the bench's end-to-end scenarios:
- the byte order through the FIFO in each direction;
- the status byte returned during the command;
- the full and empty stalls releasing at the right moment;
- aborted partial bytes leaving the FIFO contents untouched;
- the flush when the direction reverses.

// File: rtl/spi_flow_pkg.sv
package spi_flow_pkg;
  parameter int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t NODATA_MAX = 8'h0F;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WR,
    PH_RD,
    PH_IDLE
  } phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo import spi_flow_pkg::*; #(
  parameter int unsigned DEPTH = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  push_i,
  input  byte_t wdata_i,
  input  logic  pop_i,
  output byte_t head_o,
  output logic  full_o,
  output logic  empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  byte_t         mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R12
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !clr_i |-> !empty_o); // R5
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl import spi_flow_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_i,
  input  logic  ss_i,
  input  logic  mosi_i,
  input  byte_t status_i,
  input  byte_t head_i,
  input  logic  empty_i,
  input  logic  full_i,
  output logic  push_o,
  output byte_t push_data_o,
  output logic  pop_o,
  output logic  clr_o,
  output logic  dir_wr_o,
  output byte_t cmd_o,
  output logic  cmd_valid_o,
  output logic  miso_o,
  output logic  miso_oe_o,
  output logic  rdy_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic             sclk_d_q, ss_d_q;
  logic [CNT_W-1:0] bit_cnt_q;
  byte_t            rx_q, tx_q, cmd_q;
  phase_e           phase_q;
  logic             need_rd_q, dir_wr_q, cmd_vld_q, miso_q, oe_q;
  logic             rise, fall, byte_done, has_data;
  byte_t            rx_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b1;
      ss_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= sclk_i;
      ss_d_q   <= ss_i;
    end
  end

  assign rise      = !ss_i && !ss_d_q && sclk_i && !sclk_d_q;
  assign fall      = !ss_i && !ss_d_q && !sclk_i && sclk_d_q;
  assign rx_next   = {rx_q[BYTE_W-2:0], mosi_i};
  assign byte_done = rise && (bit_cnt_q == LAST_BIT);
  assign has_data  = (rx_next > NODATA_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      cmd_q     <= '0;
      phase_q   <= PH_CMD;
      need_rd_q <= 1'b0;
      dir_wr_q  <= 1'b0;
      cmd_vld_q <= 1'b0;
      miso_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      cmd_vld_q <= 1'b0;
      if (ss_i) begin
        // idle or abort: partial byte discarded
        bit_cnt_q <= '0;
        phase_q   <= PH_CMD;
        need_rd_q <= 1'b0;
        oe_q      <= 1'b0;
      end else if (ss_d_q) begin
        tx_q      <= status_i;
        miso_q    <= status_i[BYTE_W-1];
        oe_q      <= 1'b1;
        bit_cnt_q <= '0;
        phase_q   <= PH_CMD;
      end else begin
        if (rise) begin
          rx_q      <= rx_next;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
          if (byte_done) begin
            unique case (phase_q)
              PH_CMD: begin
                cmd_q     <= rx_next;
                cmd_vld_q <= 1'b1;
                if (has_data) begin
                  dir_wr_q  <= rx_next[BYTE_W-1];
                  phase_q   <= rx_next[BYTE_W-1] ? PH_WR : PH_RD;
                  need_rd_q <= !rx_next[BYTE_W-1];
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
              PH_RD:   need_rd_q <= 1'b1;
              default: ;
            endcase
          end
        end
        // peek next read byte; popped only once fully sent
        if (need_rd_q && !empty_i) begin
          tx_q      <= head_i;
          need_rd_q <= 1'b0;
        end
        if (fall) miso_q <= tx_q[BYTE_W-1];
      end
    end
  end

  assign push_o      = byte_done && (phase_q == PH_WR);
  assign push_data_o = rx_next;
  assign pop_o       = byte_done && (phase_q == PH_RD);
  assign clr_o       = byte_done && (phase_q == PH_CMD) && has_data &&
                       (rx_next[BYTE_W-1] != dir_wr_q);
  assign dir_wr_o    = dir_wr_q;
  assign cmd_o       = cmd_q;
  assign cmd_valid_o = cmd_vld_q;
  assign miso_o      = miso_q;
  assign miso_oe_o   = oe_q;
  assign rdy_o       = !((need_rd_q && empty_i) || ((phase_q == PH_WR) && full_i));

  AST_BUSY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> bit_cnt_q == '0); // R7
  AST_CMD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R1
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_i |=> !miso_oe_o); // R3
  AST_NODATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_IDLE |-> !push_o && !pop_o && !clr_o); // R6
endmodule

// File: rtl/spi_flow_slave.sv
module spi_flow_slave import spi_flow_pkg::*; #(
  parameter int unsigned DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rdy_o,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              cmd_valid_o,
  input  logic              prod_valid_i,
  input  logic [BYTE_W-1:0] prod_data_i,
  output logic              prod_ready_o,
  output logic              cons_valid_o,
  output logic [BYTE_W-1:0] cons_data_o,
  input  logic              cons_ready_i
);
  logic [2:0] sync_q;
  logic       spi_push, spi_pop, fifo_clr, dir_wr;
  logic       fifo_push, fifo_pop, fifo_full, fifo_empty;
  byte_t      spi_data, fifo_wdata, fifo_head;

  spi_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, ss_ni, mosi_i}),
    .q_o   (sync_q)
  );

  spi_xfer_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sync_q[2]),
    .ss_i       (sync_q[1]),
    .mosi_i     (sync_q[0]),
    .status_i   (status_i),
    .head_i     (fifo_head),
    .empty_i    (fifo_empty),
    .full_i     (fifo_full),
    .push_o     (spi_push),
    .push_data_o(spi_data),
    .pop_o      (spi_pop),
    .clr_o      (fifo_clr),
    .dir_wr_o   (dir_wr),
    .cmd_o      (cmd_o),
    .cmd_valid_o(cmd_valid_o),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .rdy_o      (rdy_o)
  );

  assign prod_ready_o = !dir_wr && !fifo_full;
  assign cons_valid_o = dir_wr && !fifo_empty;
  assign cons_data_o  = fifo_head;
  assign fifo_push    = dir_wr ? spi_push : (prod_valid_i && prod_ready_o);
  assign fifo_wdata   = dir_wr ? spi_data : prod_data_i;
  assign fifo_pop     = dir_wr ? (cons_valid_o && cons_ready_i) : spi_pop;

  spi_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fifo_clr),
    .push_i (fifo_push),
    .wdata_i(fifo_wdata),
    .pop_i  (fifo_pop),
    .head_o (fifo_head),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );

  AST_PROD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_ready_o |-> !fifo_full); // R12
endmodule

// File: tb/spi_flow_slave_bench.sv
module spi_flow_slave_bench;
  localparam int HALF  = 8;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b1, ss_n = 1'b1, mosi = 1'b0;
  logic [7:0] status = 8'h00;
  logic       prod_valid = 1'b0, cons_ready = 1'b0;
  logic [7:0] prod_data = 8'h00;
  logic       miso_o, miso_oe_o, rdy_o, cmd_valid_o, prod_ready_o, cons_valid_o;
  logic [7:0] cmd_o, cons_data_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] got [0:1023];
  int got_n = 0;

  always #10 clk = ~clk;

  spi_flow_slave #(.DEPTH(DEPTH)) u_spi_flow_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .rdy_o(rdy_o), .status_i(status),
    .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .prod_valid_i(prod_valid),
    .prod_data_i(prod_data), .prod_ready_o(prod_ready_o), .cons_valid_o(cons_valid_o),
    .cons_data_o(cons_data_o), .cons_ready_i(cons_ready)
  );

  always @(negedge clk) begin
    if (cons_valid_o && cons_ready) begin
      got[got_n] = cons_data_o;
      got_n = got_n + 1;
    end
  end

  function automatic bit f_has_data(input logic [7:0] c);
    return c > 8'h0F;
  endfunction

  function automatic bit f_is_write(input logic [7:0] c);
    return c[7] && f_has_data(c);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - n; i--) begin
      sclk = 1'b0;
      mosi = tx[i];
      tick(HALF);
      @(negedge clk);
      rx[i] = miso_o;
      tick(1);
      sclk = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic wait_rdy();
    while (!rdy_o) tick(1);
  endtask

  task automatic begin_txn();
    ss_n = 1'b0;
    tick(HALF);
  endtask

  task automatic end_txn();
    tick(HALF);
    ss_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic push_prod(input logic [7:0] b);
    while (!prod_ready_o) tick(1);
    prod_valid = 1'b1;
    prod_data  = b;
    tick(1);
    prod_valid = 1'b0;
  endtask

  task automatic cmd_only(input logic [7:0] c);
    logic [7:0] rx;
    begin_txn();
    spi_byte(c, rx);
    end_txn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic [7:0] d [0:63];
    int base, len;
    logic [7:0] c;
    void'($urandom(32'd4711));
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // reset state
    chk("R11 rdy", int'(rdy_o), 1);
    chk("R11 prod_ready", int'(prod_ready_o), 1);
    chk("R3 oe idle", int'(miso_oe_o), 0);
    chk("R12 cons_valid", int'(cons_valid_o), 0);

    // no-data command with trailing byte
    push_prod(8'h77);
    status = 8'hA5;
    begin_txn();
    spi_byte(8'h05, rx);
    chk("R2 status", int'(rx), 'hA5);
    chk("R1 cmd", int'(cmd_o), 'h05);
    chk("R3 oe active", int'(miso_oe_o), 1);
    spi_byte(8'h3C, rx);
    end_txn();
    chk("R3 oe released", int'(miso_oe_o), 0);
    chk("R6 dir kept", int'(prod_ready_o), 1);
    begin_txn();
    spi_byte(8'h10, rx);
    wait_rdy();
    spi_byte(8'h00, rx);
    chk("R6 buffer intact", int'(rx), 'h77);
    end_txn();

    // write until full
    cons_ready = 1'b0;
    base = got_n;
    status = 8'h3C;
    begin_txn();
    spi_byte(8'h80, rx);
    chk("R2 status", int'(rx), 'h3C);
    chk("R12 prod blocked in write", int'(prod_ready_o), 0);
    for (int i = 0; i < DEPTH; i++) begin
      wait_rdy();
      d[i] = 8'($urandom);
      spi_byte(d[i], rx);
      if (i == DEPTH - 2) chk("R7 not yet full", int'(rdy_o), 1);
    end
    chk("R7 busy when full", int'(rdy_o), 0);
    cons_ready = 1'b1;
    tick(10);
    chk("R7 ready after drain", int'(rdy_o), 1);
    end_txn();
    tick(50);
    chk("R4 count", got_n - base, DEPTH);
    for (int i = 0; i < DEPTH; i++) chk("R4 order", int'(got[base + i]), int'(d[i]));

    // read with empty buffer
    status = 8'h96;
    begin_txn();
    spi_byte(8'h10, rx);
    chk("R2 status", int'(rx), 'h96);
    chk("R8 busy empty", int'(rdy_o), 0);
    tick(20);
    chk("R8 still busy", int'(rdy_o), 0);
    push_prod(8'h5A);
    tick(3);
    chk("R8 ready", int'(rdy_o), 1);
    spi_byte(8'h00, rx);
    chk("R8 next byte", int'(rx), 'h5A);
    end_txn();

    // abort in write
    cons_ready = 1'b0;
    base = got_n;
    begin_txn();
    spi_byte(8'h81, rx);
    wait_rdy();
    spi_byte(8'h11, rx);
    wait_rdy();
    spi_bits(8'hF0, 4, rx);
    end_txn();
    begin_txn();
    spi_byte(8'h82, rx);
    chk("R9 fresh cmd", int'(cmd_o), 'h82);
    wait_rdy();
    spi_byte(8'h22, rx);
    end_txn();
    cons_ready = 1'b1;
    tick(20);
    chk("R9 write count", got_n - base, 2);
    chk("R9 first", int'(got[base]), 'h11);
    chk("R9 second", int'(got[base + 1]), 'h22);

    // abort in read
    cmd_only(8'h10);
    push_prod(8'hC1);
    push_prod(8'hC2);
    begin_txn();
    spi_byte(8'h10, rx);
    spi_bits(8'h00, 3, rx);
    end_txn();
    begin_txn();
    spi_byte(8'h10, rx);
    wait_rdy();
    spi_byte(8'h00, rx);
    chk("R9 read first", int'(rx), 'hC1);
    wait_rdy();
    spi_byte(8'h00, rx);
    chk("R9 read second", int'(rx), 'hC2);
    end_txn();

    // flush on direction change
    push_prod(8'hD1);
    push_prod(8'hD2);
    cons_ready = 1'b0;
    cmd_only(8'h90);
    tick(5);
    chk("R10 read->write flush", int'(cons_valid_o), 0);
    chk("R12 prod blocked", int'(prod_ready_o), 0);
    begin_txn();
    spi_byte(8'h90, rx);
    wait_rdy();
    spi_byte(8'hE1, rx);
    end_txn();
    chk("R4 held", int'(cons_valid_o), 1);
    begin_txn();
    spi_byte(8'h10, rx);
    chk("R10 write->read flush", int'(rdy_o), 0);
    end_txn();
    chk("R10 read mode", int'(prod_ready_o), 1);
    cons_ready = 1'b1;

    // fill from producer, stream out
    for (int i = 0; i < DEPTH; i++) begin
      d[i] = 8'($urandom);
      push_prod(d[i]);
    end
    tick(2);
    chk("R12 full", int'(prod_ready_o), 0);
    status = 8'($urandom);
    begin_txn();
    spi_byte(8'h20, rx);
    chk("R2 status", int'(rx), int'(status));
    for (int i = 0; i < DEPTH; i++) begin
      wait_rdy();
      spi_byte(8'h00, rx);
      chk("R5 order", int'(rx), int'(d[i]));
    end
    chk("R8 drained", int'(rdy_o), 0);
    end_txn();

    // random mix
    for (int it = 0; it < 20; it++) begin
      c = 8'($urandom);
      if (!f_has_data(c)) c = c | 8'h10;
      len = 1 + int'($urandom % 6);
      status = 8'($urandom);
      if (f_is_write(c)) begin
        base = got_n;
        begin_txn();
        spi_byte(c, rx);
        chk("R2 status", int'(rx), int'(status));
        for (int i = 0; i < len; i++) begin
          wait_rdy();
          d[i] = 8'($urandom);
          spi_byte(d[i], rx);
        end
        end_txn();
        tick(20);
        chk("R4 count", got_n - base, len);
        for (int i = 0; i < len; i++) chk("R4 data", int'(got[base + i]), int'(d[i]));
      end else begin
        cmd_only(c);
        for (int i = 0; i < len; i++) begin
          d[i] = 8'($urandom);
          push_prod(d[i]);
        end
        begin_txn();
        spi_byte(c, rx);
        chk("R1 cmd", int'(cmd_o), int'(c));
        chk("R2 status", int'(rx), int'(status));
        for (int i = 0; i < len; i++) begin
          wait_rdy();
          spi_byte(8'h00, rx);
          chk("R5 data", int'(rx), int'(d[i]));
        end
        end_txn();
      end
    end

    report();
    $finish;
  end
endmodule